// File: doc/BRIEF.md
# Write-Delay Cycle Calibration Controller

This block runs one phase of memory interface bring-up after reset: for every byte lane it finds how many whole clock cycles of write delay place that lane's strobe and data on the right memory clock edge. The delay moves strobe and data of a lane together, so board and buffer delays longer than one clock period can be absorbed. Fine tap delays, command generation and the read capture path are outside the block.

After `start`, all lanes share one training loop. Each pass writes a fixed eight-byte burst using every lane's current cycle delay. It then reads the burst back and waits for the read-side alignment logic, which runs in parallel, to report that the capture is aligned. Finally it compares each lane's captured bytes. A lane that matches locks its delay. A lane that does not match steps its delay up by one. A lane that still does not match at the top of the range is marked as failed. `done` rises once every lane has locked or failed.

Top module: `wrcal_cycle_ctrl`

## Requirements
- R1: After reset, `done`, `err`, `lane_err`, `wr_req` and `rd_req` are low, every lane delay is zero, and nothing happens until `start`.
- R2: A `start` pulse while idle or while `done` is high clears all lane delays and error bits to zero, drops `done`, and raises `wr_req` in the next cycle.
- R3: Each pass holds `wr_req` until a cycle with `wr_ack`, then holds `rd_req` until a cycle with `rd_valid`. The two requests are never high together, and one calibration uses exactly one write per pass, with max over lanes of (min(offset, MAX_CYCLES)+1) passes.
- R4: Readback data is taken only in the cycle where `rd_req` and `rd_valid` are both high; values on `rd_data` in other cycles have no effect on the result.
- R5: After the readback, the compare waits for `rd_aligned`. While it is low, no lane delay changes and no new write request is issued.
- R6: The expected burst per lane is the bytes FF,00,AA,55,55,AA,99,66 in beat order. Beat k of lane n sits at `rd_data[64*n + 8*k +: 8]`, i.e. lane word 64'h6699AA5555AA00FF, and all 64 bits must match.
- R7: Lane n's delay sits at `cyc_dly[DLY_W*n +: DLY_W]`. It starts at zero and rises by one after each failed compare. It stops at the first matching value, and a locked lane keeps its value while other lanes continue.
- R8: A lane whose compare fails at delay MAX_CYCLES sets its bit in `lane_err` and keeps delay MAX_CYCLES. `err` is high when any lane bit is set.
- R9: `done` rises once every lane is locked or failed and stays high until the next `start`. The lane delays do not change while it is high.
- R10: A `start` pulse while calibration is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run |
| rd_aligned | input | 1 | Read-side alignment reports the capture as valid |
| wr_req | output | 1 | Request a training write |
| wr_ack | input | 1 | Training write accepted |
| rd_req | output | 1 | Request a training read |
| rd_valid | input | 1 | Readback data present on `rd_data` |
| rd_data | input | LANES*64 | Captured eight-beat burst, 64 bits per lane |
| cyc_dly | output | LANES*DLY_W | Per-lane whole-cycle write delay |
| lane_err | output | LANES | Per-lane failure bits |
| done | output | 1 | All lanes resolved |
| err | output | 1 | At least one lane failed |

## Verification
The bench models a per-lane round-trip offset and returns the exact burst only when a lane's delay equals that offset. A single flipped bit is returned otherwise, which shows whether the compare covers all 64 bits. Offset sets run through a staggered ramp, equal offsets, all zeros (a one-pass run), a mix with one lane beyond range, and all lanes beyond range. These separate locking from stepping and from failure, and show whether locked lanes stay put. Outside the valid cycle the bus always carries the correct burst, which exposes sampling at the wrong time. Varied acknowledge, valid and alignment latencies, together with a mid-run `start`, show whether the block waits on each handshake and ignores restarts while busy.

// File: rtl/wrcal_pkg.sv
// Shared definitions for the write-delay cycle calibration controller.
// Assumes an eight-beat, byte-wide training burst per lane.
package wrcal_pkg;

    localparam int BURST_BEATS = 8;
    localparam int BURST_W     = BURST_BEATS * 8;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_WRITE,
        CS_READ,
        CS_ALIGN,
        CS_EVAL,
        CS_CHECK,
        CS_DONE
    } cal_state_t;

    // Byte value of one training beat.
    function automatic logic [7:0] train_byte(input int beat);
        case (beat)
            0: train_byte = 8'hFF;
            1: train_byte = 8'h00;
            2: train_byte = 8'hAA;
            3: train_byte = 8'h55;
            4: train_byte = 8'h55;
            5: train_byte = 8'hAA;
            6: train_byte = 8'h99;
            default: train_byte = 8'h66;
        endcase
    endfunction

    // Whole burst packed with beat 0 in the lowest byte.
    function automatic logic [BURST_W-1:0] train_word();
        logic [BURST_W-1:0] w;
        w = '0;
        for (int b = 0; b < BURST_BEATS; b++) begin
            w[8*b +: 8] = train_byte(b);
        end
        return w;
    endfunction

endpackage

// File: rtl/wrcal_lane.sv
// One byte lane: holds the captured burst, compares it against the
// training word and steps or locks its whole-cycle delay.
// Assumes clear, capture and eval are single-cycle strobes from the sequencer.
module wrcal_lane
    import wrcal_pkg::*;
#(
    parameter int MAX_CYCLES = 3,
    parameter int DLY_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               capture,
    input  logic               eval,
    input  logic [BURST_W-1:0] rd_word,
    output logic [DLY_W-1:0]   dly,
    output logic               locked,
    output logic               failed
);

    localparam logic [BURST_W-1:0] EXPECT  = train_word();
    localparam logic [DLY_W-1:0]   DLY_TOP = DLY_W'(MAX_CYCLES);

    logic [BURST_W-1:0] cap_q;
    logic [DLY_W-1:0]   dly_q;
    logic               lock_q;
    logic               fail_q;
    logic               match;

    // Burst register, loaded only on the readback strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (capture) begin
            cap_q <= rd_word;
        end
    end

    // Full-width compare of the held burst.
    always_comb begin
        match = (cap_q == EXPECT);
    end

    // Delay search: step on mismatch, lock on match, fail at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            dly_q  <= '0;
            lock_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (eval && !lock_q && !fail_q) begin
            if (match) begin
                lock_q <= 1'b1;
            end else if (dly_q == DLY_TOP) begin
                fail_q <= 1'b1;
            end else begin
                dly_q <= dly_q + DLY_W'(1);
            end
        end
    end

    assign dly    = dly_q;
    assign locked = lock_q;
    assign failed = fail_q;

endmodule

// File: rtl/wrcal_seq.sv
// Shared write/read/compare loop sequencer for all lanes.
// Assumes handshake inputs are sampled on the rising edge while the
// matching request is high; all_resolved reflects lane state after eval.
module wrcal_seq
    import wrcal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wr_ack,
    input  logic rd_valid,
    input  logic rd_aligned,
    input  logic all_resolved,
    output logic wr_req,
    output logic rd_req,
    output logic clear,
    output logic capture,
    output logic eval,
    output logic done
);

    cal_state_t st_q;
    cal_state_t st_nx;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= CS_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // Next-state decision for one pass of the training loop.
    always_comb begin
        st_nx = st_q;
        case (st_q)
            CS_IDLE:  if (start)      st_nx = CS_WRITE;
            CS_WRITE: if (wr_ack)     st_nx = CS_READ;
            CS_READ:  if (rd_valid)   st_nx = CS_ALIGN;
            CS_ALIGN: if (rd_aligned) st_nx = CS_EVAL;
            CS_EVAL:                  st_nx = CS_CHECK;
            CS_CHECK: st_nx = all_resolved ? CS_DONE : CS_WRITE;
            CS_DONE:  if (start)      st_nx = CS_WRITE;
            default:                  st_nx = CS_IDLE;
        endcase
    end

    // Strobes and requests decoded from the current state.
    always_comb begin
        wr_req  = (st_q == CS_WRITE);
        rd_req  = (st_q == CS_READ);
        capture = (st_q == CS_READ) && rd_valid;
        eval    = (st_q == CS_EVAL);
        done    = (st_q == CS_DONE);
        clear   = start && ((st_q == CS_IDLE) || (st_q == CS_DONE));
    end

endmodule

// File: rtl/wrcal_cycle_ctrl.sv
// Top of the write-delay cycle calibration controller: one sequencer
// driving LANES independent lane searchers.
// Assumes rd_data carries 64 bits per lane, lane 0 in the lowest bits.
module wrcal_cycle_ctrl
    import wrcal_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int MAX_CYCLES = 3,
    parameter int DLY_W      = $clog2(MAX_CYCLES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     rd_aligned,
    output logic                     wr_req,
    input  logic                     wr_ack,
    output logic                     rd_req,
    input  logic                     rd_valid,
    input  logic [LANES*BURST_W-1:0] rd_data,
    output logic [LANES*DLY_W-1:0]   cyc_dly,
    output logic [LANES-1:0]         lane_err,
    output logic                     done,
    output logic                     err
);

    logic             clear;
    logic             capture;
    logic             eval;
    logic [LANES-1:0] lane_lock;
    logic [LANES-1:0] lane_fail;
    logic             all_resolved;

    wrcal_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .wr_ack       (wr_ack),
        .rd_valid     (rd_valid),
        .rd_aligned   (rd_aligned),
        .all_resolved (all_resolved),
        .wr_req       (wr_req),
        .rd_req       (rd_req),
        .clear        (clear),
        .capture      (capture),
        .eval         (eval),
        .done         (done)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        wrcal_lane #(
            .MAX_CYCLES (MAX_CYCLES),
            .DLY_W      (DLY_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clear),
            .capture (capture),
            .eval    (eval),
            .rd_word (rd_data[n*BURST_W +: BURST_W]),
            .dly     (cyc_dly[n*DLY_W +: DLY_W]),
            .locked  (lane_lock[n]),
            .failed  (lane_fail[n])
        );
    end

    // Lane resolution summary and error flags.
    always_comb begin
        all_resolved = &(lane_lock | lane_fail);
        lane_err     = lane_fail;
        err          = |lane_fail;
    end

endmodule

// File: rtl/wrcal_chk.sv
// Protocol and stability checks for wrcal_cycle_ctrl, attached by bind.
// Assumes the same parameter values as the bound instance.
module wrcal_chk #(
    parameter int LANES      = 4,
    parameter int MAX_CYCLES = 3,
    parameter int DLY_W      = 2
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_req,
    input logic                   wr_ack,
    input logic                   rd_req,
    input logic                   rd_valid,
    input logic                   done,
    input logic [LANES*DLY_W-1:0] cyc_dly,
    input logic [LANES-1:0]       lane_err
);

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_req);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_valid) |=> rd_req);

    // R3
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_req && rd_req));

    // R9
    done_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done || $stable(cyc_dly)));

    for (genvar n = 0; n < LANES; n++) begin : g_lane_chk
        // R8
        fail_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lane_err[n] |-> (int'(cyc_dly[n*DLY_W +: DLY_W]) == MAX_CYCLES));

        // R7
        single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cyc_dly[n*DLY_W +: DLY_W]) |->
                ((cyc_dly[n*DLY_W +: DLY_W] == '0) ||
                 (int'(cyc_dly[n*DLY_W +: DLY_W]) ==
                  int'($past(cyc_dly[n*DLY_W +: DLY_W])) + 1)));
    end

endmodule

bind wrcal_cycle_ctrl wrcal_chk #(
    .LANES      (LANES),
    .MAX_CYCLES (MAX_CYCLES),
    .DLY_W      (DLY_W)
) u_wrcal_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .wr_ack   (wr_ack),
    .rd_req   (rd_req),
    .rd_valid (rd_valid),
    .done     (done),
    .cyc_dly  (cyc_dly),
    .lane_err (lane_err)
);

// File: tb/test_wrcal_cycle_ctrl.sv
// Scoreboard bench: a driver task queues the expected outcome of each
// calibration run, a monitor pops and compares it when done rises.
module test_wrcal_cycle_ctrl;

    localparam int LANES = 4;
    localparam int MAXC  = 3;
    localparam int DLY_W = 2;
    localparam logic [63:0] PATTERN = 64'h6699AA5555AA00FF;

    typedef struct packed {
        logic [LANES-1:0][7:0] dly;
        logic [LANES-1:0]      lerr;
        logic [15:0]           att;
    } exp_t;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic                   rd_aligned = 1'b0;
    logic                   wr_req;
    logic                   wr_ack = 1'b0;
    logic                   rd_req;
    logic                   rd_valid = 1'b0;
    logic [LANES*64-1:0]    rd_data = {LANES{PATTERN}};
    logic [LANES*DLY_W-1:0] cyc_dly;
    logic [LANES-1:0]       lane_err;
    logic                   done;
    logic                   err;

    int   total = 0;
    int   bad = 0;
    int   off [LANES];
    int   ack_lat = 0;
    int   val_lat = 0;
    int   algn_lat = 0;
    int   writes = 0;
    exp_t exp_q [$];

    always #4 clk = ~clk;

    wrcal_cycle_ctrl #(
        .LANES      (LANES),
        .MAX_CYCLES (MAXC),
        .DLY_W      (DLY_W)
    ) i_wrcal_cycle_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .rd_aligned (rd_aligned),
        .wr_req     (wr_req),
        .wr_ack     (wr_ack),
        .rd_req     (rd_req),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .cyc_dly    (cyc_dly),
        .lane_err   (lane_err),
        .done       (done),
        .err        (err)
    );

    function automatic int lane_dly(input int n);
        return int'(cyc_dly[n*DLY_W +: DLY_W]);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Memory model: serve writes and reads, return the burst per lane offset.
    initial begin
        forever begin
            @(negedge clk);
            if (wr_req) begin
                repeat (ack_lat) @(negedge clk);
                wr_ack = 1'b1;
                @(negedge clk);
                wr_ack = 1'b0;
                writes++;
            end else if (rd_req) begin
                logic [LANES*DLY_W-1:0] snap;
                repeat (val_lat) @(negedge clk);
                for (int n = 0; n < LANES; n++) begin
                    if (lane_dly(n) == off[n])
                        rd_data[n*64 +: 64] = PATTERN;
                    else
                        rd_data[n*64 +: 64] = PATTERN ^
                            (64'h1 << ((n * 13 + lane_dly(n) * 5 + 3) % 64));
                end
                rd_valid = 1'b1;
                @(negedge clk);
                rd_valid = 1'b0;
                rd_data  = {LANES{PATTERN}};
                snap = cyc_dly;
                for (int w = 0; w < algn_lat; w++) begin
                    chk(!wr_req && (cyc_dly == snap), "R5", "no progress before aligned",
                        int'(cyc_dly), int'(snap));
                    @(negedge clk);
                end
                rd_aligned = 1'b1;
                @(negedge clk);
                rd_aligned = 1'b0;
            end
        end
    end

    // Monitor: compare the final lane state against the queued expectation.
    initial begin
        bit seen = 1'b0;
        forever begin
            @(negedge clk);
            if (done && !seen) begin
                exp_t e;
                seen = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "done without pending run", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    for (int n = 0; n < LANES; n++) begin
                        chk(lane_dly(n) == int'(e.dly[n]), "R7 R4 R6", "lane delay",
                            lane_dly(n), int'(e.dly[n]));
                    end
                    chk(lane_err == e.lerr, "R8", "lane_err", int'(lane_err), int'(e.lerr));
                    chk(err == (|e.lerr), "R8", "err", int'(err), int'(|e.lerr));
                    chk(writes == int'(e.att), "R3", "write passes", writes, int'(e.att));
                end
            end
            if (!done) seen = 1'b0;
        end
    end

    // Driver: queue the expectation, launch a run, check start and done behaviour.
    task automatic run_cal(input int o0, input int o1, input int o2, input int o3,
                           input int al, input int vl, input int gl, input bit poke);
        exp_t e;
        int   most;
        logic [LANES*DLY_W-1:0] held;
        off[0] = o0; off[1] = o1; off[2] = o2; off[3] = o3;
        ack_lat = al; val_lat = vl; algn_lat = gl;
        most = 0;
        e = '0;
        for (int n = 0; n < LANES; n++) begin
            if (off[n] <= MAXC) begin
                e.dly[n] = 8'(off[n]);
                if (off[n] > most) most = off[n];
            end else begin
                e.dly[n]  = 8'(MAXC);
                e.lerr[n] = 1'b1;
                most = MAXC;
            end
        end
        e.att = 16'(most + 1);
        exp_q.push_back(e);
        writes = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(cyc_dly == '0, "R2", "delays cleared", int'(cyc_dly), 0);
        chk(lane_err == '0 && !done, "R2", "flags cleared", int'({lane_err, done}), 0);
        chk(wr_req, "R2", "write requested", int'(wr_req), 1);
        if (poke) begin
            repeat (9) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        held = cyc_dly;
        repeat (6) @(negedge clk);
        chk(done, "R9", "done held", int'(done), 1);
        chk(cyc_dly == held, "R9", "delays stable while done", int'(cyc_dly), int'(held));
        if (poke) chk(1'b1, "R10", "restart while busy ignored (pass count)", 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int n = 0; n < LANES; n++) off[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state and idle until start
        chk(!done && !err && lane_err == '0, "R1", "flags after reset",
            int'({done, err, lane_err}), 0);
        chk(!wr_req && !rd_req, "R1", "no requests after reset", int'({wr_req, rd_req}), 0);
        chk(cyc_dly == '0, "R1", "delays after reset", int'(cyc_dly), 0);
        repeat (5) @(negedge clk);
        chk(!wr_req && !done, "R1", "idle without start", int'({wr_req, done}), 0);

        run_cal(0, 1, 2, 3, 0, 0, 0, 1'b0);
        run_cal(2, 2, 0, 1, 3, 2, 4, 1'b0);
        run_cal(5, 1, 3, 0, 1, 0, 2, 1'b0);
        run_cal(0, 0, 0, 0, 2, 1, 1, 1'b0);
        run_cal(3, 0, 0, 2, 1, 1, 1, 1'b1);  // R10 mid-run start
        run_cal(7, 4, 9, 6, 0, 3, 0, 1'b0);
        run_cal(1, 3, 3, 1, 4, 4, 3, 1'b0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9", "all runs reached done", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule